// File: doc/BRIEF.md
# DSP External Bus Wait-State Controller with Split SRAM Decode

This block is glue logic that sits beside a digital signal processor's external bus. It watches the program-space, data-space and I/O-space select lines, the bus strobe and the read/write line. When an access to a slow space begins, it pulls the ready line low for a fixed number of clock cycles so that the processor stalls. Each address space has its own wait count, set by a parameter from 0 to 7. A count is chosen from the memory access time t: it is the smallest N for which t is below cycle*N + offset while t is above cycle*(N-1) + offset. For the slowest processor grade, the cycle is 200 ns and the offset is 85 ns. Ready is the AND of the per-space results, so a cycle that touches several spaces is released only when every one of them has finished waiting.

The same block also decodes one 64k x 16 SRAM so that it serves as both program and data memory. The top SRAM address bit comes from the space selects: the lower 32k words hold program and the upper 32k words hold data. Chip select, output enable and write enable follow strobe and the read/write line. If a program select and a data select are driven low together, the bus is in a forbidden state. No SRAM access is made, and a sticky error flag is raised that only reset clears.

Each space has its own timer state machine with three states. TMR_IDLE means no access is pending. TMR_WAIT means stall cycles are being counted. TMR_HOLD means the wait is done and ready is held high until the access ends. The transitions are as follows:
- idle-to-wait happens on an access start when the count is 2 or more.
- idle-to-hold happens on an access start when the count is 0 or 1.
- wait-to-hold happens on the last stall cycle.
- wait-to-idle and hold-to-idle happen on release of strobe or the select.

The decoder classifies each bus cycle as BUS_NONE, BUS_PROG, BUS_DATA or BUS_CLASH. The error flag has two states, FLAG_CLEAR and FLAG_SET, and moves from clear to set on any clock edge that sees BUS_CLASH.

Top module: `dsp_wait_ctrl`

## Requirements
- R1: After reset, and in any cycle with strobe_n high, ready is 1, sram_ce_n, sram_oe_n and sram_we_n are 1, and clash_err is 0 after reset.
- R2: An access to program space is strobe_n and sel_prog_n both low. From the first cycle of such an access, ready is 0 for exactly WAIT_PROG clock cycles (default 2) and then 1 until the access ends.
- R3: Data-space accesses (sel_data_n low) and I/O-space accesses (sel_io_n low) stall for WAIT_DATA and WAIT_IO cycles. Both default to 0, and each count may be set independently from 0 to 7.
- R4: Raising strobe_n or the select returns that space's timer to idle. The next access to the same space stalls for its full count again, even if the earlier access ended before its wait completed.
- R5: When several spaces are active in the same cycle, ready stays 0 until the longest of their wait counts has elapsed.
- R6: sram_top_addr is 0 for an access with sel_prog_n low and sel_data_n high. It is 1 for an access with sel_data_n low and sel_prog_n high. It is 0 when no SRAM access is made.
- R7: sram_ce_n is 0 only while strobe_n is 0 and exactly one of sel_prog_n and sel_data_n is 0. An I/O-only access leaves sram_ce_n, sram_oe_n and sram_we_n at 1.
- R8: During an SRAM access, rd_wr_n = 1 (read) gives sram_oe_n = 0 and sram_we_n = 1, and rd_wr_n = 0 (write) gives sram_we_n = 0 and sram_oe_n = 1.
- R9: When strobe_n, sel_prog_n and sel_data_n are all 0, no SRAM select is made. From the next clock edge, clash_err is 1, and it stays 1 until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock output; timers advance on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous |
| strobe_n | input | 1 | Bus strobe, low during an external access |
| sel_prog_n | input | 1 | Program-space select, active low |
| sel_data_n | input | 1 | Data-space select, active low |
| sel_io_n | input | 1 | I/O-space select, active low |
| rd_wr_n | input | 1 | 1 for read, 0 for write |
| ready | output | 1 | High when the processor may complete the access |
| sram_top_addr | output | 1 | Top SRAM address bit (0 program half, 1 data half) |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| clash_err | output | 1 | Sticky flag for a program/data select clash |

## Verification
The assertions check the following on every cycle:
- Ready is high whenever strobe is released.
- A timer returns to idle once its access ends.
- The stall counter never exceeds its last value.
- The SRAM enables are never both low, and both stay high whenever the chip select is off.
- A clash always sets the error flag, and the flag never clears on its own.

The exact number of stall cycles per space, and the fact that combined spaces wait for the longest count, can only be shown by the bench scenarios. The same holds for a fresh full wait after an interrupted access and for the address bit matching the selected half. The bench runs two parameter sets side by side to cover counts of 0, 2, 3, 5 and 7.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    localparam int NUM_SPACES = 3;
    localparam int SPACE_PROG = 0;
    localparam int SPACE_DATA = 1;
    localparam int SPACE_IO   = 2;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_WAIT = 2'd1,
        TMR_HOLD = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_PROG  = 2'd1,
        BUS_DATA  = 2'd2,
        BUS_CLASH = 2'd3
    } bus_space_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

endpackage

// File: rtl/wsc_space_timer.sv
module wsc_space_timer
    import wsc_pkg::*;
#(
    parameter int WAITS = 2,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic stall_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'((WAITS > 0) ? (WAITS - 1) : 0);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    tmr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TMR_IDLE: begin
                if (active_i) begin
                    if (WAITS <= 1) begin
                        st_d = TMR_HOLD;
                    end else begin
                        st_d  = TMR_WAIT;
                        cnt_d = ONE;
                    end
                end
            end
            TMR_WAIT: begin
                if (!active_i) begin
                    st_d  = TMR_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d  = TMR_HOLD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            TMR_HOLD: begin
                if (!active_i) begin
                    st_d = TMR_IDLE;
                end
            end
            default: begin
                st_d  = TMR_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        stall_o = 1'b0;
        unique case (st_q)
            TMR_IDLE: stall_o = active_i && (WAITS > 0);
            TMR_WAIT: stall_o = active_i;
            TMR_HOLD: stall_o = 1'b0;
            default:  stall_o = 1'b0;
        endcase
    end

    // R4: a released access leaves the timer idle
    assert_idle_after_release_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        !active_i |=> (st_q == TMR_IDLE));

    // R2: the stall counter stays within its range
    assert_count_in_range_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q == TMR_WAIT) |-> (cnt_q != '0 && cnt_q <= LAST));

    // R2: once done, an ongoing access stays released
    assert_hold_persists_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (st_q == TMR_HOLD && active_i) |=> (st_q == TMR_HOLD));

endmodule

// File: rtl/wsc_sram_split.sv
module wsc_sram_split
    import wsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    input  logic       sel_prog_n,
    input  logic       sel_data_n,
    input  logic       rd_wr_n,
    output bus_space_e space_o,
    output logic       top_addr_o,
    output logic       ce_n_o,
    output logic       oe_n_o,
    output logic       we_n_o
);

    // classify the current bus cycle
    always_comb begin
        space_o = BUS_NONE;
        if (!strobe_n) begin
            unique case ({sel_prog_n, sel_data_n})
                2'b01:   space_o = BUS_PROG;
                2'b10:   space_o = BUS_DATA;
                2'b00:   space_o = BUS_CLASH;
                default: space_o = BUS_NONE;
            endcase
        end
    end

    // drive the SRAM lines from the class
    always_comb begin
        top_addr_o = 1'b0;
        ce_n_o     = 1'b1;
        oe_n_o     = 1'b1;
        we_n_o     = 1'b1;
        unique case (space_o)
            BUS_PROG: begin
                top_addr_o = 1'b0;
                ce_n_o     = 1'b0;
                oe_n_o     = !rd_wr_n;
                we_n_o     = rd_wr_n;
            end
            BUS_DATA: begin
                top_addr_o = 1'b1;
                ce_n_o     = 1'b0;
                oe_n_o     = !rd_wr_n;
                we_n_o     = rd_wr_n;
            end
            BUS_CLASH: ;
            BUS_NONE:  ;
            default:   ;
        endcase
    end

    // R8: output and write enables never overlap
    assert_no_enable_overlap_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !(oe_n_o == 1'b0 && we_n_o == 1'b0));

    // R7: deselected SRAM has both enables off
    assert_idle_enables_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        ce_n_o |-> (oe_n_o && we_n_o));

    // R9: a clash never reaches the SRAM
    assert_clash_no_select_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!strobe_n && !sel_prog_n && !sel_data_n) |-> ce_n_o);

endmodule

// File: rtl/wsc_clash_flag.sv
module wsc_clash_flag
    import wsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_space_e space_i,
    output logic       flag_o
);

    flag_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FLAG_CLEAR;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_CLEAR: if (space_i == BUS_CLASH) st_d = FLAG_SET;
            FLAG_SET:   st_d = FLAG_SET;
            default:    st_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (st_q == FLAG_SET);
    end

    // R9: a clash raises the flag at the next edge
    assert_clash_sets_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (space_i == BUS_CLASH) |=> flag_o);

    // R9: the flag only clears through reset
    assert_flag_sticky_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        flag_o |=> flag_o);

endmodule

// File: rtl/dsp_wait_ctrl.sv
module dsp_wait_ctrl
    import wsc_pkg::*;
#(
    parameter int MAX_WAIT  = 7,
    parameter int WAIT_PROG = 2,
    parameter int WAIT_DATA = 0,
    parameter int WAIT_IO   = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    input  logic sel_prog_n,
    input  logic sel_data_n,
    input  logic sel_io_n,
    input  logic rd_wr_n,
    output logic ready,
    output logic sram_top_addr,
    output logic sram_ce_n,
    output logic sram_oe_n,
    output logic sram_we_n,
    output logic clash_err
);

    localparam int CNT_W = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1);

    logic [NUM_SPACES-1:0] space_act;
    logic [NUM_SPACES-1:0] space_stall;
    bus_space_e            bus_space;

    assign space_act[SPACE_PROG] = !strobe_n && !sel_prog_n;
    assign space_act[SPACE_DATA] = !strobe_n && !sel_data_n;
    assign space_act[SPACE_IO]   = !strobe_n && !sel_io_n;

    for (genvar k = 0; k < NUM_SPACES; k++) begin : g_space
        localparam int WK = (k == SPACE_PROG) ? WAIT_PROG :
                            (k == SPACE_DATA) ? WAIT_DATA : WAIT_IO;
        wsc_space_timer #(
            .WAITS (WK),
            .CNT_W (CNT_W)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (space_act[k]),
            .stall_o  (space_stall[k])
        );
    end

    assign ready = ~|space_stall;

    wsc_sram_split u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n   (strobe_n),
        .sel_prog_n (sel_prog_n),
        .sel_data_n (sel_data_n),
        .rd_wr_n    (rd_wr_n),
        .space_o    (bus_space),
        .top_addr_o (sram_top_addr),
        .ce_n_o     (sram_ce_n),
        .oe_n_o     (sram_oe_n),
        .we_n_o     (sram_we_n)
    );

    wsc_clash_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .space_i (bus_space),
        .flag_o  (clash_err)
    );

    // R1: no strobe, no stall
    assert_ready_when_idle_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        strobe_n |-> ready);

    // R6: the data half is chosen only by a data select
    assert_top_addr_space_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        sram_top_addr |-> (!sel_data_n && sel_prog_n && !strobe_n));

endmodule

// File: tb/tb_dsp_wait_ctrl.sv
`timescale 1ns/1ps
module tb_dsp_wait_ctrl;

    localparam int A_PROG = 2, A_DATA = 0, A_IO = 0;
    localparam int B_PROG = 7, B_DATA = 5, B_IO = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_n = 1'b1, sel_prog_n = 1'b1, sel_data_n = 1'b1, sel_io_n = 1'b1, rd_wr_n = 1'b1;
    logic ready, top_addr, ce_n, oe_n, we_n, err;
    logic b_ready, b_top, b_ce, b_oe, b_we, b_err;

    int checks = 0;
    int errors = 0;
    bit err_exp = 1'b0;

    always #2.5 clk = ~clk;

    dsp_wait_ctrl #(.WAIT_PROG(A_PROG), .WAIT_DATA(A_DATA), .WAIT_IO(A_IO)) dut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .sel_prog_n(sel_prog_n),
        .sel_data_n(sel_data_n), .sel_io_n(sel_io_n), .rd_wr_n(rd_wr_n),
        .ready(ready), .sram_top_addr(top_addr), .sram_ce_n(ce_n),
        .sram_oe_n(oe_n), .sram_we_n(we_n), .clash_err(err));

    dsp_wait_ctrl #(.WAIT_PROG(B_PROG), .WAIT_DATA(B_DATA), .WAIT_IO(B_IO)) dut_alt (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .sel_prog_n(sel_prog_n),
        .sel_data_n(sel_data_n), .sel_io_n(sel_io_n), .rd_wr_n(rd_wr_n),
        .ready(b_ready), .sram_top_addr(b_top), .sram_ce_n(b_ce),
        .sram_oe_n(b_oe), .sram_we_n(b_we), .clash_err(b_err));

    function automatic int exp_wait(bit p, bit d, bit io, int wp, int wd, int wi);
        int w = 0;
        if (p && wp > w) w = wp;
        if (d && wd > w) w = wd;
        if (io && wi > w) w = wi;
        return w;
    endfunction

    task automatic chk(input bit act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_idle();
        chk(ready, 1'b1, "R1", "ready idle");
        chk(b_ready, 1'b1, "R1", "alt ready idle");
        chk(ce_n, 1'b1, "R1", "ce_n idle");
        chk(oe_n, 1'b1, "R1", "oe_n idle");
        chk(we_n, 1'b1, "R1", "we_n idle");
        chk(err, err_exp, "R9", "clash flag");
    endtask

    task automatic check_cycle(input int i, input bit p, input bit d, input bit io,
                               input bit rw, input string rtag);
        bit hp = p && !d;
        bit hd = d && !p;
        bit ce_e = !(hp || hd);
        chk(ready, i >= exp_wait(p, d, io, A_PROG, A_DATA, A_IO), rtag, "ready");
        chk(b_ready, i >= exp_wait(p, d, io, B_PROG, B_DATA, B_IO), rtag, "alt ready");
        chk(top_addr, hd, "R6", "top address bit");
        chk(ce_n, ce_e, "R7", "chip select");
        chk(oe_n, ce_e ? 1'b1 : !rw, "R8", "output enable");
        chk(we_n, ce_e ? 1'b1 : rw, "R8", "write enable");
        chk(err, err_exp, "R9", "clash flag");
    endtask

    // starts and ends at a falling edge
    task automatic run_access(input bit p, input bit d, input bit io, input bit rw,
                              input int len, input string rtag);
        strobe_n = 1'b0;
        sel_prog_n = !p; sel_data_n = !d; sel_io_n = !io; rd_wr_n = rw;
        for (int i = 0; i < len; i++) begin
            #1;
            check_cycle(i, p, d, io, rw, rtag);
            @(posedge clk);
            if (p && d) err_exp = 1'b1;
            @(negedge clk);
        end
        strobe_n = 1'b1;
        sel_prog_n = 1'b1; sel_data_n = 1'b1; sel_io_n = 1'b1; rd_wr_n = 1'b1;
        #1;
        check_idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check_idle();                     // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle();                     // R1 after reset
        @(negedge clk);

        run_access(1, 0, 0, 1, 5, "R2");  // program read, 2 / 7 waits
        run_access(1, 0, 0, 0, 9, "R2");  // program write
        run_access(0, 1, 0, 0, 7, "R3");  // data write, 0 / 5 waits
        run_access(0, 1, 0, 1, 6, "R3");  // data read
        run_access(0, 0, 1, 1, 6, "R3");  // I/O only: no SRAM select
        run_access(1, 0, 0, 1, 1, "R4");  // cut short mid-wait
        run_access(1, 0, 0, 1, 4, "R4");  // full wait again
        run_access(0, 1, 0, 1, 2, "R4");
        run_access(0, 1, 0, 1, 8, "R4");
        run_access(0, 1, 1, 1, 8, "R5");  // longest of 5 and 3
        run_access(1, 0, 1, 0, 10, "R5"); // longest of 7 and 3

        for (int n = 0; n < 60; n++) begin
            int pick = $urandom_range(0, 4);
            bit p  = (pick == 0) || (pick == 3);
            bit d  = (pick == 1) || (pick == 4);
            bit io = (pick == 2) || (pick >= 3);
            run_access(p, d, io, 1'($urandom_range(0, 1)), $urandom_range(1, 10), "R5");
        end

        run_access(1, 1, 0, 1, 3, "R9");  // clash
        run_access(0, 1, 0, 1, 7, "R9");  // flag stays set
        chk(err, 1'b1, "R9", "flag sticky");
        rst_n = 1'b0;
        err_exp = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(err, 1'b0, "R9", "flag cleared by reset");
        check_idle();
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule